// File: doc/BRIEF.md
# Translation PTE Read Staging Register

This block holds a copy of an instruction-translation page-table entry on its way to the integer register file. Software cannot move an entry straight out of the translation buffer. It first issues an access to the buffer, and the selected entry lands in the staging copy. It then issues a processor-register read of the staging copy, which returns the entry as a 64-bit word. Every access to the translation buffer overwrites the staging copy, whether the access is a read or a write. Software should therefore read the staging copy soon after the access it is interested in.

The access port is a valid/ready stream carrying a write flag, an entry index and a compact entry value. A write loads the compact value directly. A read drives an index to the external entry array. The array answers one cycle later, and that answer is loaded on the following edge. While a read is in flight, `acc_ready` is low, so an access offered then is held off and not taken. The register-read port is also valid/ready, backed by a single response register. A request is accepted only when that register is empty or is being drained in the same cycle (`rq_ready = !rsp_valid || rsp_ready`). A response stays valid and unchanged until `rsp_ready` is seen high. The privileged-mode input gates the read: outside privileged mode the response is zero and flagged illegal.

Top module: `pte_stage`

## Requirements
- R1: While and after reset the staging copy is all zeros: `acc_ready` is 1, `rsp_valid` is 0, `rsp_data` is 0 and `rsp_illegal` is 0, and the first privileged read returns zero.
- R2: An access accepted with `acc_write`=1 loads `acc_wpte` into the staging copy on the same edge.
- R3: An access accepted with `acc_write`=0 drives `arr_rd_en`=1 and `arr_rd_idx`=`acc_index` in that cycle. The `arr_rdata` value present in the next cycle is loaded into the staging copy at the end of that next cycle.
- R4: `acc_ready` is 0 for exactly the one cycle after an accepted read access, and 1 otherwise. An access offered while `acc_ready` is 0 has no effect.
- R5: The compact entry layout is: bit 25 address-space-match, bits 24:4 frame number, bit 3 user, bit 2 supervisor, bit 1 executive, bit 0 kernel read-enable. The output word places these at bit 34, bits 33:13, and bits 12, 11, 10, 9 respectively, and every other bit reads as zero.
- R6: A request accepted with `priv`=1 yields, one cycle later, `rsp_valid`=1, `rsp_illegal`=0 and `rsp_data` equal to the packed staging copy.
- R7: A request accepted with `priv`=0 yields `rsp_valid`=1, `rsp_illegal`=1 and `rsp_data`=0, and it leaves the staging copy unchanged.
- R8: A request accepted on the same edge that loads the staging copy returns the previous contents. The new contents are returned by requests accepted on later edges.
- R9: `rq_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, the response holds its data and flag. A response taken with no new request leaves `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Translation-buffer access offered |
| acc_ready | output | 1 | Access can be taken this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_index | input | IDX_W | Entry index for a read access |
| acc_wpte | input | 26 | Compact entry value for a write access |
| arr_rd_en | output | 1 | Read strobe to the entry array |
| arr_rd_idx | output | IDX_W | Entry index to the entry array |
| arr_rdata | input | 26 | Compact entry returned by the array one cycle after the strobe |
| priv | input | 1 | Processor is in privileged mode |
| rq_valid | input | 1 | Staging-register read requested |
| rq_ready | output | 1 | Read request can be taken |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 64 | Packed entry word, or zero if illegal |
| rsp_illegal | output | 1 | Response came from a non-privileged read |

## Verification
Each result has its own due cycle. A write access changes what is read back from the next request onward. A read access shows its array strobe combinationally in the accepting cycle and reaches the staging copy two edges later. A register read produces its response one edge after acceptance. The bench runs a behavioural model that advances on the same edges with these latencies. It drives inputs just after the falling edge and compares every output a moment later, so the combinational strobe and ready signals are judged against the current inputs, and the registered outputs against the state after the last rising edge. Stimulus includes accesses and reads on the same edge, accesses offered during the in-flight cycle, and stalled responses, so each stated latency is observed.

// File: rtl/pte_stage_pkg.sv
package pte_stage_pkg;
  parameter int PFN_W   = 21;
  parameter int PFN_LSB = 13;
  parameter int WORD_W  = 64;
  parameter int NRE     = 4;

  localparam int CPTE_W  = 1 + PFN_W + NRE;
  localparam int ASM_POS = PFN_LSB + PFN_W;
  localparam int RE_LSB  = PFN_LSB - NRE;

  typedef logic [CPTE_W-1:0] cpte_t;
  typedef logic [WORD_W-1:0] word_t;

  // Spread the compact entry over the architectural word; unused bits stay zero.
  function automatic word_t pack_word(cpte_t c);
    word_t w;
    w = '0;
    w[ASM_POS]              = c[CPTE_W-1];
    w[PFN_LSB +: PFN_W]     = c[NRE +: PFN_W];
    w[RE_LSB +: NRE]        = c[NRE-1:0];
    return w;
  endfunction
endpackage

// File: rtl/pte_stage_access.sv
module pte_stage_access
  import pte_stage_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_index,
  input  cpte_t            acc_wpte,
  output logic             arr_rd_en,
  output logic [IDX_W-1:0] arr_rd_idx,
  input  cpte_t            arr_rdata,
  output logic             load_en,
  output cpte_t            load_val
);
  logic acc_fire;
  logic rd_pend_q;

  assign acc_ready  = !rd_pend_q;
  assign acc_fire   = acc_valid && acc_ready;
  assign arr_rd_en  = acc_fire && !acc_write;
  assign arr_rd_idx = acc_index;

  // One cycle of array latency: the returned entry is taken while pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend_q <= 1'b0;
    else        rd_pend_q <= arr_rd_en;
  end

  always_comb begin
    load_en  = 1'b0;
    load_val = acc_wpte;
    if (rd_pend_q) begin
      load_en  = 1'b1;
      load_val = arr_rdata;
    end else if (acc_fire && acc_write) begin
      load_en  = 1'b1;
    end
  end
endmodule

// File: rtl/pte_stage_hold.sv
module pte_stage_hold
  import pte_stage_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  cpte_t load_val,
  output cpte_t stage_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stage_q <= '0;
    else if (load_en) stage_q <= load_val;
  end
endmodule

// File: rtl/pte_stage_resp.sv
module pte_stage_resp
  import pte_stage_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  priv,
  input  cpte_t stage_q,
  input  logic  rq_valid,
  output logic  rq_ready,
  output logic  rsp_valid,
  input  logic  rsp_ready,
  output word_t rsp_data,
  output logic  rsp_illegal
);
  logic  rq_fire;
  word_t packed_w;

  assign rq_ready = !rsp_valid || rsp_ready;
  assign rq_fire  = rq_valid && rq_ready;
  assign packed_w = pack_word(stage_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_illegal <= 1'b0;
    end else if (rq_fire) begin
      rsp_valid   <= 1'b1;
      rsp_data    <= priv ? packed_w : '0;
      rsp_illegal <= !priv;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/pte_stage.sv
module pte_stage
  import pte_stage_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  output logic               acc_ready,
  input  logic               acc_write,
  input  logic [IDX_W-1:0]   acc_index,
  input  logic [CPTE_W-1:0]  acc_wpte,
  output logic               arr_rd_en,
  output logic [IDX_W-1:0]   arr_rd_idx,
  input  logic [CPTE_W-1:0]  arr_rdata,
  input  logic               priv,
  input  logic               rq_valid,
  output logic               rq_ready,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [WORD_W-1:0]  rsp_data,
  output logic               rsp_illegal
);
  logic  load_en;
  cpte_t load_val;
  cpte_t stage_q;

  pte_stage_access #(.IDX_W(IDX_W)) u_access (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .acc_write  (acc_write),
    .acc_index  (acc_index),
    .acc_wpte   (acc_wpte),
    .arr_rd_en  (arr_rd_en),
    .arr_rd_idx (arr_rd_idx),
    .arr_rdata  (arr_rdata),
    .load_en    (load_en),
    .load_val   (load_val)
  );

  pte_stage_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_val (load_val),
    .stage_q  (stage_q)
  );

  pte_stage_resp u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .priv        (priv),
    .stage_q     (stage_q),
    .rq_valid    (rq_valid),
    .rq_ready    (rq_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_illegal (rsp_illegal)
  );
endmodule

// File: rtl/pte_stage_chk.sv
module pte_stage_chk
  import pte_stage_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              acc_write,
  input logic [CPTE_W-1:0] acc_wpte,
  input logic              arr_rd_en,
  input logic [CPTE_W-1:0] arr_rdata,
  input logic              priv,
  input logic              rq_valid,
  input logic              rq_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_data,
  input logic              rsp_illegal,
  input logic [CPTE_W-1:0] stage_q
);
  localparam word_t LEGAL_BITS = pack_word('1);

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_write) |=> (stage_q == $past(acc_wpte)));

  assert_read_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !acc_write) |=> ##1 (stage_q == $past(arr_rdata)));

  assert_inflight_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |=> !acc_ready);

  assert_zero_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_data & ~LEGAL_BITS) == '0));

  assert_illegal_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready && !priv) |=> (rsp_valid && rsp_illegal && rsp_data == '0));

  assert_unpriv_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready && !priv && !acc_valid && acc_ready) |=> $stable(stage_q));

  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_illegal)));
endmodule

bind pte_stage pte_stage_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_ready   (acc_ready),
  .acc_write   (acc_write),
  .acc_wpte    (acc_wpte),
  .arr_rd_en   (arr_rd_en),
  .arr_rdata   (arr_rdata),
  .priv        (priv),
  .rq_valid    (rq_valid),
  .rq_ready    (rq_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .rsp_illegal (rsp_illegal),
  .stage_q     (stage_q)
);

// File: tb/pte_stage_test.sv
module pte_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0, acc_write = 1'b0;
  logic [IDX_W-1:0]  acc_index = '0;
  logic [25:0]       acc_wpte = '0;
  logic              acc_ready, arr_rd_en;
  logic [IDX_W-1:0]  arr_rd_idx;
  logic [25:0]       arr_rdata = '0;
  logic              priv = 1'b0, rq_valid = 1'b0, rsp_ready = 1'b1;
  logic              rq_ready, rsp_valid, rsp_illegal;
  logic [63:0]       rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";

  // Reference state
  logic [25:0] m_stage = '0;
  logic        m_pend = 1'b0;
  logic        m_rv = 1'b0;
  logic [63:0] m_rd = '0;
  logic        m_ri = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pte_stage #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_index(acc_index), .acc_wpte(acc_wpte),
    .arr_rd_en(arr_rd_en), .arr_rd_idx(arr_rd_idx), .arr_rdata(arr_rdata),
    .priv(priv), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_illegal(rsp_illegal)
  );

  function automatic logic [25:0] array_entry(logic [IDX_W-1:0] i);
    logic [20:0] f;
    f = 21'(i) * 21'd40503 + 21'h0A5A5;
    return {i[0], f, 4'(i ^ 6'h2D)};
  endfunction

  // R5 layout, written from the requirement
  function automatic logic [63:0] exp_word(logic [25:0] c);
    logic [63:0] w;
    w = '0;
    w[34]    = c[25];
    w[33:13] = c[24:4];
    w[12]    = c[3];
    w[11]    = c[2];
    w[10]    = c[1];
    w[9]     = c[0];
    return w;
  endfunction

  // Entry array: answers one cycle after the strobe
  always @(posedge clk) if (arr_rd_en) arr_rdata <= array_entry(arr_rd_idx);

  // Behavioural model stepped on the rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage <= '0; m_pend <= 0; m_rv <= 0; m_rd <= '0; m_ri <= 0;
    end else begin
      bit afire, rfire;
      afire = acc_valid && !m_pend;
      rfire = rq_valid && (!m_rv || rsp_ready);
      if (m_pend) m_stage <= arr_rdata;
      else if (afire && acc_write) m_stage <= acc_wpte;
      m_pend <= afire && !acc_write;
      if (rfire) begin
        m_rv <= 1; m_rd <= priv ? exp_word(m_stage) : 64'd0; m_ri <= !priv;
      end else if (rsp_ready) m_rv <= 0;
    end
  end

  task automatic chk(string what, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic e_en;
    e_en = acc_valid && !m_pend && !acc_write;
    chk("acc_ready", tag == "R1" ? "R1" : "R4", 64'(acc_ready), 64'(!m_pend));
    chk("arr_rd_en", "R3", 64'(arr_rd_en), 64'(e_en));
    if (e_en) chk("arr_rd_idx", "R3", 64'(arr_rd_idx), 64'(acc_index));
    chk("rq_ready", "R9", 64'(rq_ready), 64'(!m_rv || rsp_ready));
    chk("rsp_valid", tag == "R1" ? "R1" : "R9", 64'(rsp_valid), 64'(m_rv));
    if (m_rv || tag == "R1") begin
      chk("rsp_illegal", m_ri ? "R7" : tag, 64'(rsp_illegal), 64'(m_ri));
      chk("rsp_data", m_ri ? "R7" : tag, rsp_data, m_rd);
    end
  endtask

  task automatic step(bit av, bit aw, logic [IDX_W-1:0] ix, logic [25:0] wp,
                      bit rv, bit pv, bit rr);
    @(negedge clk);
    acc_valid = av; acc_write = aw; acc_index = ix; acc_wpte = wp;
    rq_valid = rv; priv = pv; rsp_ready = rr;
    #1;
    if (!done) compare_all();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, '0, '0, 0, 1, 1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lf;
    // R1: reset state
    tag = "R1";
    idle(3);
    @(negedge clk); rst_n = 1;
    step(0, 0, '0, '0, 1, 1, 1);
    idle(1);
    // R2 / R6: writes then privileged reads, several patterns
    tag = "R2";
    step(1, 1, 6'h3, 26'h3FFFFFF, 0, 1, 1);
    step(0, 0, '0, '0, 1, 1, 1);
    idle(1);
    tag = "R6";
    step(1, 1, 6'h0, 26'h2AAAAAA, 0, 1, 1);
    step(0, 0, '0, '0, 1, 1, 1);
    step(1, 1, 6'h0, 26'h1555555, 0, 1, 1);
    step(0, 0, '0, '0, 1, 1, 1);
    idle(1);
    // R3 / R4: read access, access offered during the in-flight cycle is held off
    tag = "R3";
    step(1, 0, 6'h05, '0, 0, 1, 1);
    tag = "R4";
    step(1, 1, 6'h00, 26'h0BADBAD, 0, 1, 1);
    step(0, 0, '0, '0, 1, 1, 1);
    step(0, 0, '0, '0, 1, 1, 1);
    idle(1);
    // R7: unprivileged read, then contents unchanged
    tag = "R7";
    step(0, 0, '0, '0, 1, 0, 1);
    step(0, 0, '0, '0, 1, 1, 1);
    idle(1);
    // R8: access and read on the same edge
    tag = "R8";
    step(1, 1, 6'h0, 26'h1234567, 1, 1, 1);
    step(0, 0, '0, '0, 1, 1, 1);
    step(1, 0, 6'h2A, '0, 1, 1, 1);
    step(0, 0, '0, '0, 1, 1, 1);
    step(0, 0, '0, '0, 1, 1, 1);
    idle(1);
    // R9: stalled response
    tag = "R9";
    step(0, 0, '0, '0, 1, 1, 0);
    step(1, 1, 6'h0, 26'h0F0F0F0, 1, 0, 0);
    step(0, 0, '0, '0, 1, 0, 0);
    step(0, 0, '0, '0, 1, 0, 1);
    step(0, 0, '0, '0, 0, 1, 1);
    idle(1);
    // Mixed traffic
    tag = "R6";
    lf = 32'h1ACE5;
    for (int n = 0; n < 400; n++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB4BCD35C : 32'h0);
      step(lf[0], lf[1], lf[9:4], lf[31:6], lf[2], lf[3] | lf[10], lf[11] | lf[12]);
    end
    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule